// File: doc/BRIEF.md
# Lockable One-Time-Programmable Register Bank

This block models a bank of one-time-programmable registers, 17 registers of 128 bits each by default. Each register is held as a run of 16-bit words. A request names a register index and a word offset. Three request kinds exist: read, program and lock. A blank bit reads as 1. Programming ANDs the supplied word into the stored word, so a bit can only move from 1 to 0. A register can be programmed many times, clearing more bits on each pass, until its lock bit is set.

Each register has its own lock bit, and a lock bit only ever goes from clear to set. Once it is set, the register can be read but every program request to it is refused. The lower half of register 0 is loaded at reset with a fixed identifier. That half is treated as locked at all times, whatever its lock bit holds. A refused or malformed request raises an error flag for exactly one cycle. Contents and lock bits return to their initial state only on reset.

Top module: `otp_bank`

## Requirements
- R1: After reset, every word reads 16'hFFFF except words 0 to 3 of register 0. Word k of register 0 (k = 0..3) holds bits [16k+15:16k] of the PRESET_ID parameter. All lock bits are clear.
- R2: A read request (req_op = 0) raises rd_valid for exactly one cycle, in the cycle after the request. rd_data then holds the addressed word. Without a read request, rd_valid stays low.
- R3: A program request (req_op = 1) to an unlocked, in-range word replaces the stored word with its AND with req_data. Repeated programs keep clearing bits and never set a bit back to 1. An accepted program does not raise op_err.
- R4: A program request to words 0 to 3 of register 0 is refused: op_err pulses and the word is unchanged. This holds whether or not register 0 is locked. Words 4 to 7 of register 0 stay programmable until register 0 is locked.
- R5: A lock request (req_op = 2) sets the lock bit of the named register. After that, every program request to that register is refused with op_err and leaves its contents unchanged, while reads still return the stored data.
- R6: Lock bits are one-way. Locking an already locked register is accepted without op_err and changes nothing. No request clears a lock bit.
- R7: A read of a register index at or above NUM_REGS returns 16'hFFFF with rd_valid and raises no op_err.
- R8: A program or lock request with a register index at or above NUM_REGS raises op_err and changes no stored word and no lock bit.
- R9: op_err is registered. It is high in the cycle after a refused request and low after accepted requests, reads, idle cycles and req_op = 3 (no operation).
- R10: The synchronous active-high reset rst clears all lock bits and restores every word to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 read, 1 program, 2 lock, 3 no operation |
| req_reg | input | IDX_W (5) | Register index |
| req_word | input | OFF_W (3) | Word offset within the register |
| req_data | input | WORD_BITS (16) | Data to AND in on program |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | WORD_BITS (16) | Word returned by a read |
| op_err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench uses the default parameters: 17 registers of 128 bits in 16-bit words, with PRESET_ID = 64'h5A3C_9E17_D2B4_6081. With these values the 5-bit index reaches the unused indices 17 to 31, so the bench can issue reads, programs and locks to registers that do not exist. It also places the boundary between the fixed identifier half and the writable half of register 0 between word offsets 3 and 4, and the bench programs both sides of that boundary.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        OTP_READ = 2'd0,
        OTP_PROG = 2'd1,
        OTP_LOCK = 2'd2,
        OTP_NOP  = 2'd3
    } otp_op_e;

    // Decoded actions for one request cycle
    typedef struct packed {
        logic rd;
        logic prog;
        logic lock;
        logic err;
    } otp_ctl_t;

    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/otp_req_decode.sv
module otp_req_decode
    import otp_pkg::*;
#(
    parameter int NUM_REGS     = 17,
    parameter int WPR          = 8,
    parameter int PRESET_WORDS = 4,
    parameter int IDX_W        = 5,
    parameter int OFF_W        = 3,
    parameter int ADDR_W       = 8
) (
    input  logic                 valid,
    input  logic [1:0]           op,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [OFF_W-1:0]     word_idx,
    input  logic [NUM_REGS-1:0]  lock_vec,
    output otp_ctl_t             ctl,
    output logic                 in_range,
    output logic                 preset_hit,
    output logic [ADDR_W-1:0]    addr
);

    otp_op_e    op_e;
    logic       reg_locked;
    logic [IDX_W-1:0] safe_idx;

    always_comb begin
        op_e       = otp_op_e'(op);
        in_range   = ({1'b0, reg_idx} < (IDX_W+1)'(NUM_REGS));
        safe_idx   = in_range ? reg_idx : '0;
        reg_locked = in_range && lock_vec[safe_idx];
        preset_hit = (reg_idx == '0) && (word_idx < OFF_W'(PRESET_WORDS));
        addr       = in_range ? (ADDR_W'(reg_idx) * ADDR_W'(WPR) + ADDR_W'(word_idx)) : '0;

        ctl.rd   = valid && (op_e == OTP_READ);
        ctl.prog = valid && (op_e == OTP_PROG) && in_range && !reg_locked && !preset_hit;
        ctl.lock = valid && (op_e == OTP_LOCK) && in_range;
        ctl.err  = valid && (((op_e == OTP_PROG) && !ctl.prog) ||
                             ((op_e == OTP_LOCK) && !in_range));
    end

endmodule

// File: rtl/otp_lock_bank.sv
module otp_lock_bank #(
    parameter int NUM_REGS = 17,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    output logic [NUM_REGS-1:0] lock_q
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[g] <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(g))) begin
                lock_q[g] <= 1'b1;
            end
        end

        // A set lock bit stays set until reset
        assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
            lock_q[g] |=> lock_q[g]);
    end

endmodule

// File: rtl/otp_word_store.sv
module otp_word_store #(
    parameter int DEPTH        = 136,
    parameter int WORD_BITS    = 16,
    parameter int PRESET_WORDS = 4,
    parameter int ADDR_W       = 8,
    parameter logic [PRESET_WORDS*WORD_BITS-1:0] PRESET_ID = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_BITS-1:0] wr_mask,
    input  logic                 rd_en,
    input  logic                 rd_in_range,
    output logic                 rd_valid,
    output logic [WORD_BITS-1:0] rd_data
);

    logic [WORD_BITS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i < PRESET_WORDS) begin
                    mem[i] <= PRESET_ID[i*WORD_BITS +: WORD_BITS];
                end else begin
                    mem[i] <= '1;
                end
            end
        end else if (wr_en) begin
            mem[addr] <= mem[addr] & wr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '1;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_in_range ? mem[addr] : '1;
            end
        end
    end

endmodule

// File: rtl/otp_bank.sv
module otp_bank
    import otp_pkg::*;
#(
    parameter int NUM_REGS  = 17,
    parameter int REG_BITS  = 128,
    parameter int WORD_BITS = 16,
    parameter logic [REG_BITS/2-1:0] PRESET_ID = 64'h5A3C_9E17_D2B4_6081,
    localparam int WPR   = REG_BITS / WORD_BITS,
    localparam int IDX_W = width_of(NUM_REGS),
    localparam int OFF_W = width_of(WPR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [IDX_W-1:0]     req_reg,
    input  logic [OFF_W-1:0]     req_word,
    input  logic [WORD_BITS-1:0] req_data,
    output logic                 rd_valid,
    output logic [WORD_BITS-1:0] rd_data,
    output logic                 op_err
);

    localparam int PRESET_WORDS = WPR / 2;
    localparam int DEPTH        = NUM_REGS * WPR;
    localparam int ADDR_W       = width_of(DEPTH);

    otp_ctl_t              ctl;
    logic                  in_range;
    logic                  preset_hit;
    logic [ADDR_W-1:0]     addr;
    logic [NUM_REGS-1:0]   lock_q;

    otp_req_decode #(
        .NUM_REGS(NUM_REGS), .WPR(WPR), .PRESET_WORDS(PRESET_WORDS),
        .IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .valid(req_valid), .op(req_op), .reg_idx(req_reg), .word_idx(req_word),
        .lock_vec(lock_q), .ctl(ctl), .in_range(in_range),
        .preset_hit(preset_hit), .addr(addr)
    );

    otp_lock_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_locks (
        .clk(clk), .rst(rst), .set_en(ctl.lock), .set_idx(req_reg), .lock_q(lock_q)
    );

    otp_word_store #(
        .DEPTH(DEPTH), .WORD_BITS(WORD_BITS), .PRESET_WORDS(PRESET_WORDS),
        .ADDR_W(ADDR_W), .PRESET_ID(PRESET_ID)
    ) u_store (
        .clk(clk), .rst(rst), .wr_en(ctl.prog), .addr(addr), .wr_mask(req_data),
        .rd_en(ctl.rd), .rd_in_range(in_range), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_err <= 1'b0;
        end else begin
            op_err <= ctl.err;
        end
    end

    // Writes never reach a locked register
    assert_no_prog_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.prog && in_range) |-> !lock_q[req_reg]);

    // The identifier half is never written
    assert_preset_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.prog |-> !((req_reg == '0) && (req_word < OFF_W'(PRESET_WORDS))));

    // Read data appears exactly one cycle after a read request
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 2'd0)) |=> rd_valid);

    // Out-of-range reads return all ones
    assert_oor_read_ones_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 2'd0) && ({1'b0, req_reg} >= (IDX_W+1)'(NUM_REGS)))
        |=> (rd_data == '1));

    // Errors only follow program or lock requests
    assert_err_source_R9: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_op == 2'd0 || req_op == 2'd3) |=> !op_err);

    // Out-of-range lock and program requests are refused
    assert_oor_refused_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 2'd1 || req_op == 2'd2) &&
         ({1'b0, req_reg} >= (IDX_W+1)'(NUM_REGS))) |=> op_err);

endmodule

// File: tb/test_otp_bank.sv
module test_otp_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd3;
    logic [4:0]  req_reg = '0;
    logic [2:0]  req_word = '0;
    logic [15:0] req_data = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        op_err;

    int checks = 0;
    int failures = 0;
    logic        got_rv;
    logic [15:0] got_rd;
    logic        got_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_bank i_otp_bank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_reg(req_reg), .req_word(req_word), .req_data(req_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .op_err(op_err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] op, input logic [4:0] r, input logic [2:0] w,
                          input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_reg = r; req_word = w; req_data = d;
        @(negedge clk);
        got_rv = rd_valid; got_rd = rd_data; got_err = op_err;
        req_valid = 1'b0; req_op = 2'd3;
    endtask

    task automatic read_chk(input string req, input logic [4:0] r, input logic [2:0] w,
                            input logic [15:0] exp);
        do_req(2'd0, r, w, 16'h0);
        check(req, {15'd0, got_rv}, 16'd1);
        check(req, got_rd, exp);
        check(req, {15'd0, got_err}, 16'd0);
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        read_chk("R1 id w0", 5'd0, 3'd0, 16'h6081);
        read_chk("R1 id w1", 5'd0, 3'd1, 16'hD2B4);
        read_chk("R1 id w2", 5'd0, 3'd2, 16'h9E17);
        read_chk("R1 id w3", 5'd0, 3'd3, 16'h5A3C);
        read_chk("R1 blank r0w4", 5'd0, 3'd4, 16'hFFFF);
        read_chk("R1 blank r16w7", 5'd16, 3'd7, 16'hFFFF);
        @(negedge clk);
        check("R2 rd_valid idle", {15'd0, rd_valid}, 16'd0);
    endtask

    task automatic t_program();
        do_req(2'd1, 5'd5, 3'd2, 16'hF0F0);
        check("R3 accept", {15'd0, got_err}, 16'd0);
        read_chk("R3 first pass", 5'd5, 3'd2, 16'hF0F0);
        do_req(2'd1, 5'd5, 3'd2, 16'h0FFF);
        read_chk("R3 second pass", 5'd5, 3'd2, 16'h00F0);
        do_req(2'd1, 5'd5, 3'd2, 16'hFFFF);
        read_chk("R3 no set back", 5'd5, 3'd2, 16'h00F0);
        read_chk("R3 neighbour", 5'd5, 3'd3, 16'hFFFF);
    endtask

    task automatic t_preset();
        do_req(2'd1, 5'd0, 3'd1, 16'h0000);
        check("R4 refuse", {15'd0, got_err}, 16'd1);
        @(negedge clk);
        check("R9 err one cycle", {15'd0, op_err}, 16'd0);
        read_chk("R4 unchanged", 5'd0, 3'd1, 16'hD2B4);
        do_req(2'd1, 5'd0, 3'd3, 16'h0000);
        check("R4 refuse w3", {15'd0, got_err}, 16'd1);
        do_req(2'd1, 5'd0, 3'd4, 16'h1234);
        check("R4 upper accept", {15'd0, got_err}, 16'd0);
        read_chk("R4 upper written", 5'd0, 3'd4, 16'h1234);
    endtask

    task automatic t_lock();
        do_req(2'd1, 5'd3, 3'd0, 16'hA5A5);
        do_req(2'd2, 5'd3, 3'd0, 16'h0);
        check("R5 lock accept", {15'd0, got_err}, 16'd0);
        do_req(2'd1, 5'd3, 3'd0, 16'h0000);
        check("R5 prog refused", {15'd0, got_err}, 16'd1);
        read_chk("R5 contents kept", 5'd3, 3'd0, 16'hA5A5);
        do_req(2'd1, 5'd3, 3'd6, 16'h0000);
        check("R5 other word refused", {15'd0, got_err}, 16'd1);
        read_chk("R5 other word kept", 5'd3, 3'd6, 16'hFFFF);
        do_req(2'd2, 5'd3, 3'd0, 16'h0);
        check("R6 relock no err", {15'd0, got_err}, 16'd0);
        do_req(2'd1, 5'd3, 3'd0, 16'h0000);
        check("R6 still locked", {15'd0, got_err}, 16'd1);
        do_req(2'd2, 5'd0, 3'd0, 16'h0);
        do_req(2'd1, 5'd0, 3'd5, 16'h0000);
        check("R5 reg0 upper locked", {15'd0, got_err}, 16'd1);
        read_chk("R5 reg0 upper kept", 5'd0, 3'd5, 16'hFFFF);
        do_req(2'd1, 5'd4, 3'd0, 16'h00FF);
        check("R5 neighbour open", {15'd0, got_err}, 16'd0);
    endtask

    task automatic t_range();
        read_chk("R7 reg17", 5'd17, 3'd0, 16'hFFFF);
        read_chk("R7 reg31", 5'd31, 3'd7, 16'hFFFF);
        do_req(2'd1, 5'd20, 3'd0, 16'h0000);
        check("R8 prog oor", {15'd0, got_err}, 16'd1);
        do_req(2'd2, 5'd25, 3'd0, 16'h0);
        check("R8 lock oor", {15'd0, got_err}, 16'd1);
        read_chk("R8 reg0 w7 untouched", 5'd0, 3'd7, 16'hFFFF);
        do_req(2'd1, 5'd16, 3'd0, 16'h0F0F);
        check("R8 reg16 still open", {15'd0, got_err}, 16'd0);
        do_req(2'd3, 5'd20, 3'd0, 16'h0);
        check("R9 nop no err", {15'd0, got_err}, 16'd0);
    endtask

    task automatic t_reset_again();
        apply_reset();
        read_chk("R10 reg3 restored", 5'd3, 3'd0, 16'hFFFF);
        read_chk("R10 reg5 restored", 5'd5, 3'd2, 16'hFFFF);
        read_chk("R10 id restored", 5'd0, 3'd0, 16'h6081);
        do_req(2'd1, 5'd3, 3'd0, 16'h0F0F);
        check("R10 lock cleared", {15'd0, got_err}, 16'd0);
        read_chk("R10 prog after reset", 5'd3, 3'd0, 16'h0F0F);
    endtask

    initial begin
        apply_reset();
        check("R1 err after reset", {15'd0, op_err}, 16'd0);
        check("R2 rd_valid after reset", {15'd0, rd_valid}, 16'd0);
        t_reset_state();
        t_program();
        t_preset();
        t_lock();
        t_range();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule